// File: doc/BRIEF.md
# Output Channel Translation Table with Credit Flow Control

This block sits beside the register file in a processor core that sends all of its results over an on-chip network. The core names its destinations with a small logical channel number. This table turns that number into a 20-bit physical network address, which is either a point-to-point address or a multicast address. For every logical channel it also keeps an end-to-end credit count. A send goes onto the network only while the receiver is known to have buffer space for it.

The decode stage presents a channel on the access port and sees the decoded destination at once, in the same cycle. The fields it sees are the tile, the position inside the tile, the destination channel, the multicast core mask and, for memory targets, the bank. The bank is chosen from the low bits of the memory address, because cache lines are spread across the eight banks. When the stage asserts its send request, it gets a grant in the same cycle, and the credit is consumed at the next clock edge. The execute stage rewrites entries through the write port. Credit returns from the receivers arrive on their own port. The highest channel is a null channel. It accepts every send and generates no traffic. Fetch and fill operations always use channel 0.

Top module: `chan_map_table`

## Requirements
- R1: After a synchronous active-low reset, every entry holds address 0, is unicast and holds 4 credits.
- R2: When `wr_en` is high at a clock edge, entry `wr_chan` takes `wr_addr` and `wr_mcast`, and its credits reload to 4. The access port shows the new values from the next cycle.
- R3: When `acc_fetch` is high, the access port uses entry 0, whatever the value of `acc_chan`.
- R4: For a unicast entry, `acc_tile` is address bits 19:12 and `acc_dchan` is bits 3:0. For a core target, `acc_pos` is bits 7:4 and `acc_mask` is 0.
- R5: For a multicast entry, `acc_mask` is address bits 11:4 (bit 0 selects core 0) and `acc_dchan` is bits 3:0. `acc_tile`, `acc_pos`, `acc_is_mem` and `acc_bank` are 0.
- R6: A unicast entry whose address bit 7 is set (positions 8 to 15) is a memory target. For it, `acc_is_mem`=1, `acc_bank`=`acc_mem_addr[7:5]` (32-byte lines), and `acc_pos`=8+bank. For any other entry, `acc_bank`=0.
- R7: For channels 0 to 14, `acc_grant` = `acc_send` and (credits ≠ 0). A granted send lowers that channel's credits by one at the next edge.
- R8: A credit return (`cr_en`, `cr_chan`) raises that channel's credits by one, saturating at 4. `acc_credits` shows the current count.
- R9: A granted send and a credit return on the same channel in the same cycle leave its count unchanged. A write to that channel in the same cycle takes priority and reloads 4.
- R10: Channel 15 is null. `acc_null`=1, `acc_grant` follows `acc_send`, all destination fields read 0 and `acc_credits` reads 4. Writes and credit returns aimed at channel 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe from execute |
| wr_chan | input | 4 | Logical channel to write |
| wr_addr | input | 20 | Physical address to store |
| wr_mcast | input | 1 | Stored address is multicast |
| acc_chan | input | 4 | Logical channel looked up in decode |
| acc_fetch | input | 1 | Fetch/fill access, forces channel 0 |
| acc_send | input | 1 | Request to send on the looked-up channel |
| acc_mem_addr | input | 32 | Memory address used for bank choice |
| cr_en | input | 1 | Credit return strobe |
| cr_chan | input | 4 | Channel receiving the credit |
| acc_grant | output | 1 | Send permitted this cycle |
| acc_null | output | 1 | Looked-up channel is the null channel |
| acc_mcast | output | 1 | Entry is multicast |
| acc_tile | output | 8 | Destination tile |
| acc_pos | output | 4 | Destination position in tile |
| acc_dchan | output | 4 | Destination input channel |
| acc_mask | output | 8 | Multicast core mask |
| acc_is_mem | output | 1 | Destination is a memory bank |
| acc_bank | output | 3 | Selected memory bank |
| acc_credits | output | 3 | Current credit count of the channel |

## Verification
Several updates can land on one counter in the same cycle: a granted send, a credit return and a table write. The bench points the lookup, the credit return port and the write port at the same channel in the same cycle, both in a directed sequence and in a long stretch where traffic is confined to a few channels. A behavioural model keeps one integer per channel. On every cycle the bench compares the credit count and the grant from the model with those from the design. A wrong net result therefore shows up on the first later lookup of that channel.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
// Package: shared field layout and entry type of the output channel table.
// Assumes a 20-bit physical address: tile [19:12], position [7:4],
// channel [3:0] for unicast, and core mask [11:4] for multicast.
package cmt_pkg;
    localparam int ADDR_W   = 20;
    localparam int TILE_LSB = 12;
    localparam int TILE_W   = 8;
    localparam int POS_LSB  = 4;
    localparam int POS_W    = 4;
    localparam int DCH_W    = 4;
    localparam int MASK_LSB = 4;
    localparam int MASK_W   = 8;

    typedef struct packed {
        logic              mcast;
        logic [ADDR_W-1:0] addr;
    } cmt_entry_t;
endpackage

// File: rtl/cmt_credit_ctr.sv
`timescale 1ns/1ps
// Module: per-channel credit counter.
// What it does: holds a saturating credit count. A reload sets it to the maximum,
// a take lowers it by one and a give raises it by one. A take and a give together
// cancel each other.
// Assumes: the caller raises take only while count is nonzero.
module cmt_credit_ctr #(
    parameter int CREDIT_MAX = 4,
    parameter int CW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL = CW'(CREDIT_MAX);

    // Count update: reload has priority, then take and give net out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= FULL;
        else if (reload)
            count <= FULL;
        else if (take && !give)
            count <= count - CW'(1);
        else if (give && !take && count < FULL)
            count <= count + CW'(1);
    end

    AST_CREDIT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL); // R8
    AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> count != '0); // R7
    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == FULL); // R2
    AST_TAKE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && !reload) |=> count == $past(count) - CW'(1)); // R7
    AST_TAKE_GIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give && !reload) |=> $stable(count)); // R9
endmodule

// File: rtl/cmt_addr_decode.sv
`timescale 1ns/1ps
// Module: physical address field decoder.
// What it does: splits a stored entry into tile, position, channel and mask.
// It flags memory targets and chooses the interleaved bank from the low bits
// of the memory address.
// Assumes: purely combinational. A null entry arrives here as all zeros.
module cmt_addr_decode
    import cmt_pkg::*;
#(
    parameter int MEM_AW    = 32,
    parameter int LINE_LOG2 = 5,
    parameter int BANK_W    = 3
) (
    input  cmt_entry_t         entry,
    input  logic [MEM_AW-1:0]  mem_addr,
    output logic [TILE_W-1:0]  tile,
    output logic [POS_W-1:0]   pos,
    output logic [DCH_W-1:0]   dchan,
    output logic [MASK_W-1:0]  mask,
    output logic               is_mem,
    output logic [BANK_W-1:0]  bank
);
    localparam logic [POS_W-1:0] MEM_BASE = {1'b1, {(POS_W-1){1'b0}}};

    // Field split: multicast yields only mask and channel, unicast yields the rest.
    always_comb begin
        tile   = '0;
        pos    = '0;
        mask   = '0;
        is_mem = 1'b0;
        bank   = '0;
        dchan  = entry.addr[DCH_W-1:0];
        if (entry.mcast) begin
            mask = entry.addr[MASK_LSB +: MASK_W];
        end else begin
            tile   = entry.addr[TILE_LSB +: TILE_W];
            is_mem = entry.addr[POS_LSB + POS_W - 1];
            if (is_mem) begin
                bank = mem_addr[LINE_LOG2 +: BANK_W];
                pos  = MEM_BASE | POS_W'(bank);
            end else begin
                pos = entry.addr[POS_LSB +: POS_W];
            end
        end
    end
endmodule

// File: rtl/chan_map_table.sv
`timescale 1ns/1ps
// Module: output channel translation table with credit flow control (top).
// What it does: stores one physical address per logical channel and keeps one
// credit counter per real channel. It serves a combinational lookup-and-send
// port for decode and a write port for execute.
// Assumes: one lookup per cycle. The last channel is null and keeps no state.
// Fetch/fill accesses always use channel 0.
module chan_map_table
    import cmt_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int CREDIT_MAX = 4,
    parameter int MEM_AW     = 32,
    parameter int LINE_LOG2  = 5,
    parameter int BANK_W     = 3,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_mcast,
    input  logic [CH_W-1:0]    acc_chan,
    input  logic               acc_fetch,
    input  logic               acc_send,
    input  logic [MEM_AW-1:0]  acc_mem_addr,
    input  logic               cr_en,
    input  logic [CH_W-1:0]    cr_chan,
    output logic               acc_grant,
    output logic               acc_null,
    output logic               acc_mcast,
    output logic [TILE_W-1:0]  acc_tile,
    output logic [POS_W-1:0]   acc_pos,
    output logic [DCH_W-1:0]   acc_dchan,
    output logic [MASK_W-1:0]  acc_mask,
    output logic               acc_is_mem,
    output logic [BANK_W-1:0]  acc_bank,
    output logic [CW-1:0]      acc_credits
);
    localparam logic [CH_W-1:0] NULL_CH = CH_W'(NUM_CH - 1);
    localparam logic [CH_W-1:0] FETCH_CH = '0;

    cmt_entry_t        tbl    [NUM_CH];
    logic [CW-1:0]     credit [NUM_CH];
    logic [CH_W-1:0]   sel;
    cmt_entry_t        cur;
    logic              unused_mem_bits;

    assign unused_mem_bits = ^{acc_mem_addr[MEM_AW-1:LINE_LOG2+BANK_W],
                               acc_mem_addr[LINE_LOG2-1:0]};

    // Channel select: fetch/fill overrides the requested channel.
    assign sel      = acc_fetch ? FETCH_CH : acc_chan;
    assign acc_null = (sel == NULL_CH);

    // Entry storage: reset to unicast address 0; the null slot is never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) tbl[i] <= '0;
        end else if (wr_en && wr_chan != NULL_CH) begin
            tbl[wr_chan] <= '{mcast: wr_mcast, addr: wr_addr};
        end
    end

    // Per-channel credit counters; the null channel reports a fixed full count.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == NUM_CH - 1) begin : g_null
            assign credit[g] = CW'(CREDIT_MAX);
        end else begin : g_real
            logic take_g, give_g, reload_g;
            assign take_g   = acc_grant && (sel == CH_W'(g));
            assign give_g   = cr_en && (cr_chan == CH_W'(g));
            assign reload_g = wr_en && (wr_chan == CH_W'(g));
            cmt_credit_ctr #(.CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .reload (reload_g),
                .take   (take_g),
                .give   (give_g),
                .count  (credit[g])
            );
        end
    end

    // Lookup result: null channel reads as an empty unicast entry.
    assign cur         = acc_null ? '0 : tbl[sel];
    assign acc_mcast   = cur.mcast;
    assign acc_credits = credit[sel];
    assign acc_grant   = acc_send && (acc_null || credit[sel] != '0);

    cmt_addr_decode #(.MEM_AW(MEM_AW), .LINE_LOG2(LINE_LOG2), .BANK_W(BANK_W)) u_dec (
        .entry    (cur),
        .mem_addr (acc_mem_addr),
        .tile     (acc_tile),
        .pos      (acc_pos),
        .dchan    (acc_dchan),
        .mask     (acc_mask),
        .is_mem   (acc_is_mem),
        .bank     (acc_bank)
    );

    AST_NULL_ALWAYS_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_send && acc_null) |-> acc_grant); // R10
    AST_NULL_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        acc_null |-> (acc_tile == '0 && acc_mask == '0 && !acc_is_mem)); // R10
    AST_GRANT_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && !acc_null) |-> acc_credits != '0); // R7
    AST_MCAST_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mcast |-> (!acc_is_mem && acc_tile == '0 && acc_pos == '0)); // R5
    AST_MEM_POS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_is_mem |-> acc_pos[POS_W-1]); // R6
endmodule

// File: tb/sim_chan_map_table.sv
`timescale 1ns/1ps
// Bench: behavioural per-channel model compared on every clock.
module sim_chan_map_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_mcast = 0, acc_fetch = 0, acc_send = 0, cr_en = 0;
    logic [3:0]  wr_chan = 0, acc_chan = 0, cr_chan = 0;
    logic [19:0] wr_addr = 0;
    logic [31:0] acc_mem_addr = 0;
    logic        acc_grant, acc_null, acc_mcast, acc_is_mem;
    logic [7:0]  acc_tile, acc_mask;
    logic [3:0]  acc_pos, acc_dchan;
    logic [2:0]  acc_bank, acc_credits;

    int n_cmp = 0, n_bad = 0;
    string phase = "R1";
    int m_addr [16];
    int m_mc   [16];
    int m_cr   [16];

    always #4 clk = ~clk;

    chan_map_table u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr),
        .wr_mcast(wr_mcast), .acc_chan(acc_chan), .acc_fetch(acc_fetch),
        .acc_send(acc_send), .acc_mem_addr(acc_mem_addr), .cr_en(cr_en),
        .cr_chan(cr_chan), .acc_grant(acc_grant), .acc_null(acc_null),
        .acc_mcast(acc_mcast), .acc_tile(acc_tile), .acc_pos(acc_pos),
        .acc_dchan(acc_dchan), .acc_mask(acc_mask), .acc_is_mem(acc_is_mem),
        .acc_bank(acc_bank), .acc_credits(acc_credits)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual=%0h expected=%0h at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model for the inputs now applied.
    task automatic compare();
        int s, a, mc, cr, nul, mem, bank, pos, tile, mask;
        s   = acc_fetch ? 0 : int'(acc_chan);
        nul = (s == 15);
        a   = nul ? 0 : m_addr[s];
        mc  = nul ? 0 : m_mc[s];
        cr  = nul ? 4 : m_cr[s];
        tile = 0; pos = 0; mask = 0; mem = 0; bank = 0;
        if (mc != 0) mask = (a >> 4) & 8'hFF;
        else begin
            tile = (a >> 12) & 8'hFF;
            mem  = (a >> 7) & 1;
            if (mem != 0) begin bank = (acc_mem_addr >> 5) & 7; pos = 8 + bank; end
            else pos = (a >> 4) & 4'hF;
        end
        chk("R10", "null",    acc_null,    nul);
        chk("R2",  "mcast",   acc_mcast,   mc);
        chk("R8",  "credits", acc_credits, cr);
        chk("R7",  "grant",   acc_grant,   (acc_send && (nul || cr > 0)) ? 1 : 0);
        chk("R4",  "tile",    acc_tile,    tile);
        chk("R4",  "dchan",   acc_dchan,   a & 4'hF);
        chk("R5",  "mask",    acc_mask,    mask);
        chk("R6",  "is_mem",  acc_is_mem,  mem);
        chk("R6",  "bank",    acc_bank,    bank);
        chk("R6",  "pos",     acc_pos,     pos);
    endtask

    // Advance the model by one clock edge using the inputs held across it.
    task automatic model_edge();
        int s, cr0, g;
        s   = acc_fetch ? 0 : int'(acc_chan);
        cr0 = (s == 15) ? 4 : m_cr[s];
        g   = (acc_send && s != 15 && cr0 > 0) ? 1 : 0;
        for (int c = 0; c < 15; c++) begin
            int tk, gv;
            tk = (g != 0 && s == c) ? 1 : 0;
            gv = (cr_en && int'(cr_chan) == c) ? 1 : 0;
            if (wr_en && int'(wr_chan) == c) begin
                m_addr[c] = int'(wr_addr); m_mc[c] = int'(wr_mcast); m_cr[c] = 4;
            end else if (tk != 0 && gv == 0) m_cr[c]--;
            else if (gv != 0 && tk == 0 && m_cr[c] < 4) m_cr[c]++;
        end
    endtask

    task automatic step(bit we, int wch, int wa, bit wm, int ch, bit f, bit sd,
                        int ma, bit ce, int cch);
        @(negedge clk);
        wr_en = we; wr_chan = 4'(wch); wr_addr = 20'(wa); wr_mcast = wm;
        acc_chan = 4'(ch); acc_fetch = f; acc_send = sd; acc_mem_addr = 32'(ma);
        cr_en = ce; cr_chan = 4'(cch);
        #2 compare();
        @(posedge clk);
        #1 model_edge();
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) begin m_addr[c] = 0; m_mc[c] = 0; m_cr[c] = 4; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of every channel
        phase = "R1";
        for (int c = 0; c < 16; c++) step(0, 0, 0, 0, c, 0, 0, 0, 0, 0);
        // R2 writes: unicast core, unicast memory, multicast, ignored null write (R10)
        phase = "R2";
        step(1, 1, 'h3A056, 0, 0, 0, 0, 0, 0, 0);
        step(1, 2, 'h01092, 0, 1, 0, 0, 0, 0, 0);
        step(1, 3, 'h00A54, 1, 2, 0, 0, 'hE0, 0, 0);
        step(1, 15, 'hFFFFF, 1, 3, 0, 0, 0, 0, 0);
        phase = "R4_R5_R6";
        for (int b = 0; b < 8; b++) step(0, 0, 0, 0, 2, 0, 0, (b << 5) | 'h1F, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 'hFF, 0, 0);
        step(0, 0, 0, 0, 3, 0, 0, 'hFF, 0, 0);
        phase = "R10";
        step(0, 0, 0, 0, 15, 0, 1, 'hFF, 1, 15);
        step(0, 0, 0, 0, 15, 0, 1, 0, 0, 0);
        // R3: fetch forces channel 0
        phase = "R3";
        step(1, 0, 'h7F0C3, 0, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 2, 1, 0, 'h60, 0, 0);
        step(0, 0, 0, 0, 15, 1, 1, 0, 0, 0);
        // R7: drain channel 1 past zero
        phase = "R7";
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        // R8: returns saturate at four
        phase = "R8";
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 1, 1);
        // R9: send and return together; write beats send
        phase = "R9";
        step(0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 1, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0, 1, 0, 1, 1);
        step(1, 1, 'h2A0F1, 0, 1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R9 mixed traffic on a few channels so collisions are frequent
        phase = "R9_mix";
        for (int k = 0; k < 4000; k++) begin
            int ch, wch, cch;
            ch  = ($urandom_range(0, 9) == 0) ? 15 : $urandom_range(0, 3);
            wch = ($urandom_range(0, 9) == 0) ? 15 : $urandom_range(0, 3);
            cch = ($urandom_range(0, 9) == 0) ? 15 : $urandom_range(0, 3);
            step($urandom_range(0, 15) == 0, wch, $urandom_range(0, 'hFFFFF),
                 $urandom_range(0, 1) == 1, ch, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 2) == 0, cch);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule